// File: doc/BRIEF.md
# Stream and Configuration Hold Monitor

This block is a synthesizable protocol monitor that sits beside an engine and watches two hold rules. The first is that the engine's configuration group (mode, length and base fields) stays frozen on every cycle the engine reports busy. The second is that a streaming output that is stalled, meaning valid is high and ready is low, keeps both its data and its valid unchanged into the following cycle. The monitor only observes: it never drives the watched interface and never judges what the data means.

Each rule has its own error pulse, which is high in the cycle in which the violation is visible. Each rule also has its own sticky bit, which is set by the pulse and cleared by a shared clear input. The monitor keeps one cycle of history of the watched signals. A history-valid bit masks every check during reset and on the first cycle after reset.

Top module: `stall_hold_monitor`

## Requirements
- R1: While rst_ni is low, both error pulses and both sticky bits are 0.
- R2: In a cycle where busy_i is 1 and the concatenation {mode, length, base} differs from its value in the previous cycle, cfg_err_o is 1 in that same cycle.
- R3: In a cycle where busy_i is 0, cfg_err_o is 0 whatever the configuration fields do.
- R4: The three fields are compared as one group. Any non-empty subset of changed fields raises the single cfg_err_o and nothing else. A group held equal to the previous cycle gives cfg_err_o = 0 even while busy.
- R5: If the previous cycle had out_valid_i = 1 and out_ready_i = 0, and out_data_i now differs from its previous value, stall_err_o is 1 in the current cycle.
- R6: If the previous cycle was a stall and out_valid_i is now 0, stall_err_o is 1 even when out_data_i is held.
- R7: If the previous cycle was not a stall (valid low or ready high), stall_err_o is 0 whatever valid and data do now.
- R8: Each sticky bit (cfg_err_sticky_o, stall_err_sticky_o) reads 1 from the cycle after its pulse. It stays 1 until err_clear_i is sampled high with no new pulse, and reads 0 from the cycle after that.
- R9: When a pulse and err_clear_i occur in the same cycle, the sticky bit is set. The set wins over the clear.
- R10: On the first cycle after rst_ni rises, both pulses are 0 even if the watched signals changed relative to their values during reset.
- R11: The two rules are independent. A config violation never sets stall_err_sticky_o, and a stall violation never sets cfg_err_sticky_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Engine busy; the config must stay frozen while this is high |
| cfg_mode_i | input | MODE_W | Configuration mode field |
| cfg_len_i | input | LEN_W | Configuration length field |
| cfg_base_i | input | BASE_W | Configuration base field |
| out_valid_i | input | 1 | Watched stream valid |
| out_ready_i | input | 1 | Watched stream ready |
| out_data_i | input | DATA_W | Watched stream data |
| err_clear_i | input | 1 | Clears both sticky bits |
| cfg_err_o | output | 1 | Config-frozen violation, same-cycle pulse |
| stall_err_o | output | 1 | Stall-hold violation, same-cycle pulse |
| cfg_err_sticky_o | output | 1 | Sticky config violation flag |
| stall_err_sticky_o | output | 1 | Sticky stall violation flag |

## Verification
The bench sweeps every previous-cycle valid/ready pair against every current valid value, with data held and with data changed. A design that checked data but not valid would miss the held-data valid drop. A design that ignored the ready term would flag normal transfers. It also sweeps busy against all eight subsets of changed configuration fields. A monitor comparing only some fields, or one that ignored busy, would give wrong pulses. Reset release with changed inputs is aimed at a missing history bit, which would fire a false pulse on the first cycle. A clear that coincides with a violation is aimed at a clear-wins sticky, which would drop the new error.

// File: rtl/shm_pkg.sv
`timescale 1ns/1ps
package shm_pkg;
  localparam int unsigned SHM_NUM_ERR   = 2;
  localparam int unsigned SHM_IDX_CFG   = 0;
  localparam int unsigned SHM_IDX_STALL = 1;
endpackage

// File: rtl/shm_cfg_freeze.sv
`timescale 1ns/1ps
module shm_cfg_freeze #(
  parameter int unsigned CFG_W = 52
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hist_vld_i,
  input  logic             busy_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             err_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_i;
  end

  // whole group compared at once: one flag for any field change
  assign err_o = hist_vld_i & busy_i & (cfg_i != cfg_q);

  assert_cfg_change_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_vld_i && busy_i && !$stable(cfg_i)) |-> err_o);

  assert_idle_cfg_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !err_o);

  assert_held_cfg_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_vld_i && $stable(cfg_i)) |-> !err_o);
endmodule

// File: rtl/shm_stall_hold.sv
`timescale 1ns/1ps
module shm_stall_hold #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hist_vld_i,
  input  logic              valid_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              err_o
);
  logic              stall_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_q <= 1'b0;
      data_q  <= '0;
    end else begin
      stall_q <= valid_i & ~ready_i;
      data_q  <= data_i;
    end
  end

  // after a stall both valid and data must persist
  assign err_o = hist_vld_i & stall_q & (~valid_i | (data_i != data_q));

  assert_stall_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_vld_i && $past(valid_i && !ready_i) && valid_i && !$stable(data_i)) |-> err_o);

  assert_stall_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_vld_i && $past(valid_i && !ready_i) && !valid_i) |-> err_o);

  assert_no_stall_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_vld_i && !$past(valid_i && !ready_i)) |-> !err_o);
endmodule

// File: rtl/shm_sticky.sv
`timescale 1ns/1ps
module shm_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;  // set beats clear
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_sticky_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  assert_sticky_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  assert_sticky_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/stall_hold_monitor.sv
`timescale 1ns/1ps
module stall_hold_monitor
  import shm_pkg::*;
#(
  parameter int unsigned MODE_W = 4,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned BASE_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic              out_valid_i,
  input  logic              out_ready_i,
  input  logic [DATA_W-1:0] out_data_i,
  input  logic              err_clear_i,
  output logic              cfg_err_o,
  output logic              stall_err_o,
  output logic              cfg_err_sticky_o,
  output logic              stall_err_sticky_o
);
  localparam int unsigned CFG_W = MODE_W + LEN_W + BASE_W;

  logic                   hist_vld_q;
  logic [CFG_W-1:0]       cfg_bus;
  logic [SHM_NUM_ERR-1:0] pulse;
  logic [SHM_NUM_ERR-1:0] sticky;

  // masks checks until one edge of history exists
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_vld_q <= 1'b0;
    else         hist_vld_q <= 1'b1;
  end

  assign cfg_bus = {cfg_mode_i, cfg_len_i, cfg_base_i};

  shm_cfg_freeze #(.CFG_W(CFG_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hist_vld_i (hist_vld_q),
    .busy_i     (busy_i),
    .cfg_i      (cfg_bus),
    .err_o      (pulse[SHM_IDX_CFG])
  );

  shm_stall_hold #(.DATA_W(DATA_W)) u_stall (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hist_vld_i (hist_vld_q),
    .valid_i    (out_valid_i),
    .ready_i    (out_ready_i),
    .data_i     (out_data_i),
    .err_o      (pulse[SHM_IDX_STALL])
  );

  for (genvar g = 0; g < SHM_NUM_ERR; g++) begin : g_sticky
    shm_sticky u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (pulse[g]),
      .clr_i  (err_clear_i),
      .flag_o (sticky[g])
    );
  end

  assign cfg_err_o          = pulse[SHM_IDX_CFG];
  assign stall_err_o        = pulse[SHM_IDX_STALL];
  assign cfg_err_sticky_o   = sticky[SHM_IDX_CFG];
  assign stall_err_sticky_o = sticky[SHM_IDX_STALL];

  assert_first_cycle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hist_vld_q |-> !(cfg_err_o || stall_err_o));

  assert_cfg_not_stall_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && !stall_err_o && !stall_err_sticky_o) |=> !stall_err_sticky_o);
endmodule

// File: tb/sim_stall_hold_monitor.sv
`timescale 1ns/1ps
module sim_stall_hold_monitor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        busy_i = 1'b0;
  logic [3:0]  cfg_mode_i = '0;
  logic [15:0] cfg_len_i = '0;
  logic [31:0] cfg_base_i = '0;
  logic        out_valid_i = 1'b0;
  logic        out_ready_i = 1'b0;
  logic [31:0] out_data_i = '0;
  logic        err_clear_i = 1'b0;
  logic        cfg_err_o, stall_err_o, cfg_err_sticky_o, stall_err_sticky_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  stall_hold_monitor u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i),
    .cfg_mode_i(cfg_mode_i), .cfg_len_i(cfg_len_i), .cfg_base_i(cfg_base_i),
    .out_valid_i(out_valid_i), .out_ready_i(out_ready_i), .out_data_i(out_data_i),
    .err_clear_i(err_clear_i),
    .cfg_err_o(cfg_err_o), .stall_err_o(stall_err_o),
    .cfg_err_sticky_o(cfg_err_sticky_o), .stall_err_sticky_o(stall_err_sticky_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: outputs quiet while in reset
    for (int i = 0; i < 3; i++) begin
      tick();
      busy_i = 1'b1; out_valid_i = 1'b1; out_ready_i = 1'b0;
      cfg_len_i = 16'(i); out_data_i = 32'(i);
      #1;
      chk("R1 cfg_err", cfg_err_o, 1'b0);
      chk("R1 stall_err", stall_err_o, 1'b0);
      chk("R1 cfg_sticky", cfg_err_sticky_o, 1'b0);
      chk("R1 stall_sticky", stall_err_sticky_o, 1'b0);
    end
    // R10: release with changed inputs, no pulse on first cycle
    tick();
    rst_ni = 1'b1;
    cfg_len_i = 16'hBEEF; out_data_i = 32'hDEAD_0000; out_valid_i = 1'b0;
    #1;
    chk("R10 cfg_err", cfg_err_o, 1'b0);
    chk("R10 stall_err", stall_err_o, 1'b0);
    tick();
    busy_i = 1'b0; out_valid_i = 1'b0; err_clear_i = 1'b1;
    #1;
    chk("R10 stall_err second", stall_err_o, 1'b0);

    // Stall sweep: R5 R6 R7 R9
    for (int k = 0; k < 16; k++) begin
      logic pv, pr, cv, dchg, exp;
      logic [31:0] d0;
      pv = k[0]; pr = k[1]; cv = k[2]; dchg = k[3];
      d0 = 32'h1234_0000 + 32'(k * 7);
      exp = pv & ~pr & (~cv | dchg);
      tick();
      busy_i = 1'b0; err_clear_i = 1'b1;
      out_valid_i = pv; out_ready_i = pr; out_data_i = d0;
      tick();
      out_valid_i = cv; out_ready_i = 1'b1; out_data_i = dchg ? d0 ^ 32'h1 : d0;
      #1;
      chk(pv & ~pr & ~cv ? "R6 stall valid drop" : (pv & ~pr ? "R5 stall data" : "R7 no stall"),
          stall_err_o, exp);
      chk("R11 cfg quiet in stall sweep", cfg_err_o, 1'b0);
      tick();
      err_clear_i = 1'b0; out_valid_i = 1'b0; out_ready_i = 1'b1;
      #1;
      chk("R7 after transfer", stall_err_o, 1'b0);
      chk("R9 stall sticky set wins", stall_err_sticky_o, exp);
      chk("R11 cfg sticky untouched", cfg_err_sticky_o, 1'b0);
    end

    // Config sweep: R2 R3 R4 R9
    for (int k = 0; k < 16; k++) begin
      logic b, exp;
      logic [2:0] m;
      b = k[3]; m = k[2:0];
      exp = b & (m != 3'b000);
      tick();
      out_valid_i = 1'b0; err_clear_i = 1'b1; busy_i = 1'b0;
      cfg_mode_i = 4'(k); cfg_len_i = 16'h1000 + 16'(k); cfg_base_i = 32'hA000_0000 + 32'(k);
      tick();
      busy_i = b;
      cfg_mode_i = cfg_mode_i ^ {3'b0, m[2]};
      cfg_len_i  = cfg_len_i  ^ {15'b0, m[1]};
      cfg_base_i = cfg_base_i ^ {31'b0, m[0]};
      #1;
      chk(b ? (m == 0 ? "R4 held cfg" : "R2 cfg change") : "R3 not busy", cfg_err_o, exp);
      chk("R11 stall quiet in cfg sweep", stall_err_o, 1'b0);
      tick();
      busy_i = 1'b1; err_clear_i = 1'b0;
      #1;
      chk("R4 single cycle pulse", cfg_err_o, 1'b0);
      chk("R9 cfg sticky set wins", cfg_err_sticky_o, exp);
      chk("R11 stall sticky untouched", stall_err_sticky_o, 1'b0);
    end

    // R8: sticky hold and clear
    tick();
    busy_i = 1'b1; err_clear_i = 1'b1;
    tick();
    err_clear_i = 1'b0; cfg_base_i = cfg_base_i + 32'h100;
    #1;
    chk("R2 pulse for hold test", cfg_err_o, 1'b1);
    for (int i = 0; i < 4; i++) begin
      tick();
      busy_i = 1'b0; cfg_base_i = cfg_base_i + 32'h1;
      #1;
      chk("R8 sticky held", cfg_err_sticky_o, 1'b1);
    end
    tick();
    err_clear_i = 1'b1;
    #1;
    chk("R8 still set during clear cycle", cfg_err_sticky_o, 1'b1);
    tick();
    err_clear_i = 1'b0;
    #1;
    chk("R8 cleared", cfg_err_sticky_o, 1'b0);

    // R8 stall side: long stall held correctly, then data change
    tick();
    err_clear_i = 1'b0; out_valid_i = 1'b1; out_ready_i = 1'b0; out_data_i = 32'h55;
    for (int i = 0; i < 3; i++) begin
      tick();
      #1;
      chk("R5 held stall quiet", stall_err_o, 1'b0);
    end
    tick();
    out_data_i = 32'h56;
    #1;
    chk("R5 data change in long stall", stall_err_o, 1'b1);
    tick();
    out_ready_i = 1'b1;
    #1;
    chk("R8 stall sticky set", stall_err_sticky_o, 1'b1);
    chk("R11 cfg sticky stays clear", cfg_err_sticky_o, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule